// File: doc/BRIEF.md
# Three-Wire Latched Configuration Port

This block receives configuration words over a three-wire serial link (serial clock, serial data, load strobe) and keeps them in four parallel holding registers. Bits enter a 24-bit shift register on each rising serial clock, most significant bit first. A rising load strobe copies the assembled word into one of the holding registers. The two least significant bits of the word choose which one: the control word, the reference divider word, the feedback divider word or the test word. The serial inputs may be asynchronous to the system clock. They are resynchronised before any edge is detected.

The stored words drive decoded fields on parallel outputs. These cover the divider values, pulse-width and lock-precision settings, multiplexer select, polarity and tristate controls, and a charge-pump gain bit that both the control word and the feedback word can write. The block also produces two controls. `pd_active` is the power-down state, entered at once or after two reference-divider edges, depending on the mode written. `cnt_hold` keeps the dividers in their load state. A read-back port returns any stored word as it was written, reserved bits included.

Top module: `cfg_serial_port`

## Requirements
- R1: The shift register is 24 bits wide and takes `ser_data` on each rising `ser_clk`, most significant bit first. The last 24 bits shifted before a load form the word.
- R2: On a rising `ser_load`, the word is stored in the register selected by word bits [1:0]: 00 control, 01 reference, 10 feedback, 11 test. The other three registers keep their contents.
- R3: Fields from the reference word: `ref_div` = bits [15:2], `abp_width` = [17:16], `ld_precise` = [18], `bsc_div` = [21:20].
- R3 (continued): Fields from the feedback word: `out_div` = bits [6:2], `fb_div` = [20:8].
- R3 (continued): Fields from the control word: `mux_sel` = [7:5], `pd_polarity` = [8], `cp_tristate` = [9].
- R4: `cp_gain` equals the gain bit of the most recent write that carries one: bit 10 of a control word or bit 21 of a feedback word.
- R5: A control word with bit 20 = 1 and bit 21 = 0 sets `pd_active` in the cycle after it is stored. A control word with bit 20 = 0 clears `pd_active` and cancels any pending power-down.
- R6: A control word with bits 21 and 20 both 1 arms a power-down. `pd_active` then rises in the cycle after the second `ref_div_edge` pulse that follows the store, and stays low after the first.
- R7: `cnt_hold` is high while control bit 4 is 1 or while `pd_active` is high.
- R8: While `pd_active` is high, serial writes are still accepted and stored.
- R9: The test word is stored on every write. `test_q` shows test-word bits [23:2] only while reference word bit 19 is 1, and is zero otherwise.
- R10: `rb_word` returns the full stored word of the register chosen by `rb_sel` (encoded as in R2), reserved bits as written.
- R11: After reset, all stored words are zero and `cp_gain`, `pd_active`, `cnt_hold` and `test_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, shifts on rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, stores word on rising edge |
| ref_div_edge | input | 1 | One-cycle pulse per reference divider output edge |
| rb_sel | input | 2 | Read-back register select |
| ref_div | output | 14 | Reference divide value |
| abp_width | output | 2 | Anti-dead-zone pulse width code |
| ld_precise | output | 1 | Lock-detect precision select |
| bsc_div | output | 2 | Band-select clock divide code |
| fb_div | output | 13 | Feedback divide value |
| out_div | output | 5 | Output divider value |
| mux_sel | output | 3 | Output multiplexer select |
| pd_polarity | output | 1 | Phase detector polarity |
| cp_tristate | output | 1 | Charge pump tristate |
| cp_gain | output | 1 | Shared charge-pump gain bit |
| pd_active | output | 1 | Power-down in effect |
| cnt_hold | output | 1 | Dividers held in load state |
| test_q | output | 22 | Gated test-word payload |
| rb_word | output | 24 | Read-back of the selected stored word |

## Verification
Walking-one patterns are swept through the 14-bit and 13-bit divider fields, and every output-divider value is written. A swapped or shifted bit therefore shows up at a unique field position rather than being masked by symmetric data. All four addresses are written with distinct pseudo-random words and read back. Routing errors and reserved-bit loss are visible because each word differs from the others in every byte. The shared gain bit is exercised in all write orders and values, so a version that honours only one source is caught. Power-down is tried in asynchronous, synchronous, cancelled and written-while-down cases, with the reference edge count checked at one edge and at two.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int PD_EDGES    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_load,
  input  logic        ref_div_edge,
  input  logic [1:0]  rb_sel,
  output logic [13:0] ref_div,
  output logic [1:0]  abp_width,
  output logic        ld_precise,
  output logic [1:0]  bsc_div,
  output logic [12:0] fb_div,
  output logic [4:0]  out_div,
  output logic [2:0]  mux_sel,
  output logic        pd_polarity,
  output logic        cp_tristate,
  output logic        cp_gain,
  output logic        pd_active,
  output logic        cnt_hold,
  output logic [21:0] test_q,
  output logic [23:0] rb_word
);
  localparam int S  = SYNC_STAGES;
  localparam int EW = $clog2(PD_EDGES + 1);
  localparam logic [1:0] A_CTL = 2'b00, A_REF = 2'b01, A_FB = 2'b10, A_TST = 2'b11;

  logic [S:0] ck_sy, dt_sy, ld_sy;
  logic [WORD_W-1:0] shreg;
  logic [3:0][WORD_W-1:0] lat;
  logic cpg_q, pd_q, pd_wait;
  logic [EW-1:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sy <= '0;
      dt_sy <= '0;
      ld_sy <= '0;
    end else begin
      ck_sy <= {ck_sy[S-1:0], ser_clk};
      dt_sy <= {dt_sy[S-1:0], ser_data};
      ld_sy <= {ld_sy[S-1:0], ser_load};
    end

  wire ck_rise = ck_sy[S-1] & ~ck_sy[S];
  wire ld_rise = ld_sy[S-1] & ~ld_sy[S];
  wire ld_ctl  = ld_rise && shreg[1:0] == A_CTL;
  wire ld_fb   = ld_rise && shreg[1:0] == A_FB;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else if (ck_rise) shreg <= {shreg[WORD_W-2:0], dt_sy[S-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat <= '0;
    else if (ld_rise) lat[shreg[1:0]] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cpg_q <= 1'b0;
    else if (ld_ctl) cpg_q <= shreg[10];
    else if (ld_fb) cpg_q <= shreg[21];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd_q     <= 1'b0;
      pd_wait  <= 1'b0;
      edge_cnt <= '0;
    end else if (ld_ctl) begin
      if (!shreg[20]) begin
        pd_q    <= 1'b0;
        pd_wait <= 1'b0;
      end else if (!shreg[21]) begin
        pd_q    <= 1'b1;
        pd_wait <= 1'b0;
      end else begin
        pd_wait  <= 1'b1;
        edge_cnt <= '0;
      end
    end else if (pd_wait && ref_div_edge) begin
      if (edge_cnt == EW'(PD_EDGES - 1)) begin
        pd_q    <= 1'b1;
        pd_wait <= 1'b0;
      end else begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end

  assign ref_div     = lat[A_REF][15:2];
  assign abp_width   = lat[A_REF][17:16];
  assign ld_precise  = lat[A_REF][18];
  assign bsc_div     = lat[A_REF][21:20];
  assign out_div     = lat[A_FB][6:2];
  assign fb_div      = lat[A_FB][20:8];
  assign mux_sel     = lat[A_CTL][7:5];
  assign pd_polarity = lat[A_CTL][8];
  assign cp_tristate = lat[A_CTL][9];
  assign cp_gain     = cpg_q;
  assign pd_active   = pd_q;
  assign cnt_hold    = lat[A_CTL][4] | pd_q;
  assign test_q      = lat[A_REF][19] ? lat[A_TST][23:2] : '0;
  assign rb_word     = lat[rb_sel];

  AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(ref_div) && $stable(fb_div) && $stable(mux_sel)); // R2
  AST_CPG_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ctl |=> cp_gain == $past(shreg[10])); // R4
  AST_CPG_FB: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fb |=> cp_gain == $past(shreg[21])); // R4
  AST_ASYNC_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctl && shreg[20] && !shreg[21]) |=> pd_active); // R5
  AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctl && !shreg[20]) |=> !pd_active); // R5
  AST_SYNC_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_active) && !$past(ld_ctl)) |-> $past(ref_div_edge)); // R6
endmodule

// File: tb/cfg_serial_port_tb_top.sv
module cfg_serial_port_tb_top;
  localparam int HOLD = 4;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_load = 0, ref_div_edge = 0;
  logic [1:0] rb_sel = 0;
  logic [13:0] ref_div; logic [1:0] abp_width; logic ld_precise; logic [1:0] bsc_div;
  logic [12:0] fb_div; logic [4:0] out_div; logic [2:0] mux_sel;
  logic pd_polarity, cp_tristate, cp_gain, pd_active, cnt_hold;
  logic [21:0] test_q; logic [23:0] rb_word;
  int n_chk = 0, n_fail = 0;
  logic [23:0] e [4];
  logic e_cpg = 0, e_pd = 0;

  always #4 clk = ~clk;

  cfg_serial_port dut_i (.clk, .rst_n, .ser_clk, .ser_data, .ser_load, .ref_div_edge, .rb_sel,
    .ref_div, .abp_width, .ld_precise, .bsc_div, .fb_div, .out_div, .mux_sel, .pd_polarity,
    .cp_tristate, .cp_gain, .pd_active, .cnt_hold, .test_q, .rb_word);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_data = w[i]; ser_clk = 0; wait_n(HOLD);
      ser_clk = 1; wait_n(HOLD);
    end
    ser_clk = 0; wait_n(HOLD);
    ser_load = 1; wait_n(HOLD);
    ser_load = 0; wait_n(HOLD);
    e[w[1:0]] = w;
    if (w[1:0] == 2'b00) begin
      e_cpg = w[10];
      if (!w[20]) e_pd = 0; else if (!w[21]) e_pd = 1;
    end else if (w[1:0] == 2'b10) e_cpg = w[21];
  endtask

  task automatic pulse_ref();
    ref_div_edge = 1; wait_n(1); ref_div_edge = 0; wait_n(2);
  endtask

  task automatic check_fields(input string req);
    chk(req, "ref_div", ref_div, e[1][15:2]);
    chk(req, "abp_width", abp_width, e[1][17:16]);
    chk(req, "ld_precise", ld_precise, e[1][18]);
    chk(req, "bsc_div", bsc_div, e[1][21:20]);
    chk(req, "fb_div", fb_div, e[2][20:8]);
    chk(req, "out_div", out_div, e[2][6:2]);
    chk(req, "mux_sel", mux_sel, e[0][7:5]);
    chk(req, "pd_polarity", pd_polarity, e[0][8]);
    chk(req, "cp_tristate", cp_tristate, e[0][9]);
  endtask

  task automatic check_rb(input string req);
    for (int s = 0; s < 4; s++) begin
      rb_sel = 2'(s); wait_n(1);
      chk(req, $sformatf("rb_word[%0d]", s), rb_word, e[s]);
    end
  endtask

  function automatic logic [23:0] mk_ref(input logic [13:0] r, input logic [1:0] abp,
      input logic ldp, input logic ten, input logic [1:0] bsc, input logic [1:0] res);
    return {res, bsc, ten, ldp, abp, r, 2'b01};
  endfunction

  function automatic logic [23:0] mk_fb(input logic [12:0] b, input logic [4:0] a,
      input logic cpg, input logic [2:0] res);
    return {res[2:1], cpg, b, res[0], a, 2'b10};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [23:0] lf;
    for (int s = 0; s < 4; s++) e[s] = '0;
    wait_n(3); rst_n = 1; wait_n(2);
    // R11 reset state
    check_fields("R11");
    chk("R11", "cp_gain", cp_gain, 0);
    chk("R11", "pd_active", pd_active, 0);
    chk("R11", "cnt_hold", cnt_hold, 0);
    chk("R11", "test_q", test_q, 0);
    check_rb("R11");

    // R1 R3 walking ones through the reference divider field
    for (int i = 0; i < 14; i++) begin
      send(mk_ref(14'(1) << i, 2'(i), 1'(i), 1'b0, 2'(i + 1), 2'(i)));
      chk("R1", "ref_div walk", ref_div, 14'(1) << i);
      check_fields("R3");
    end
    send(mk_ref(14'd16383, 2'd3, 1'b1, 1'b0, 2'd3, 2'd0));
    chk("R3", "ref_div max", ref_div, 16383);

    // R1 R3 walking ones through the feedback field, all output divider values
    for (int i = 0; i < 13; i++) begin
      send(mk_fb(13'(1) << i, 5'(i), 1'b0, 3'(i)));
      chk("R1", "fb_div walk", fb_div, 13'(1) << i);
      check_fields("R3");
    end
    for (int a = 0; a < 32; a++) begin
      send(mk_fb(13'd8191 - 13'(a), 5'(a), 1'(a), 3'(a)));
      chk("R3", "out_div sweep", out_div, a);
      chk("R3", "fb_div sweep", fb_div, 8191 - a);
    end

    // R2 R10 address routing with distinct pseudo-random words
    lf = 24'h5A3C96;
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < 4; s++) begin
        lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
        send({lf[23:2], 2'(s)} & ((s == 0) ? 24'h0FFFFF : 24'hFFFFFF));
        check_rb("R2");
      end
      check_fields("R10");
    end
    send(24'h000000);

    // R4 shared gain bit, every order and value
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 2; f++) begin
        send({13'd0, 1'(c), 10'd0});
        send(mk_fb(13'd100, 5'd4, 1'(f), 3'd0));
        chk("R4", "cp_gain ctl then fb", cp_gain, f);
        send(mk_fb(13'd100, 5'd4, 1'(f), 3'd0));
        send({13'd0, 1'(c), 10'd0});
        chk("R4", "cp_gain fb then ctl", cp_gain, c);
      end

    // R7 counter reset bit
    send(24'h000010);
    chk("R7", "cnt_hold bit4", cnt_hold, 1);
    chk("R7", "pd_active bit4", pd_active, 0);
    send(24'h000000);
    chk("R7", "cnt_hold clear", cnt_hold, 0);

    // R5 asynchronous power-down and release
    send(24'h100000);
    chk("R5", "pd_active async", pd_active, 1);
    chk("R7", "cnt_hold in pd", cnt_hold, 1);
    // R8 writes accepted while down
    send(mk_ref(14'd77, 2'd1, 1'b1, 1'b0, 2'd2, 2'd3));
    chk("R8", "ref_div in pd", ref_div, 77);
    check_rb("R8");
    chk("R8", "pd held", pd_active, 1);
    send(24'h000000);
    chk("R5", "pd_active release", pd_active, 0);

    // R6 synchronous power-down counts two reference edges
    send(24'h300000);
    chk("R6", "pd before edges", pd_active, 0);
    pulse_ref();
    chk("R6", "pd after one edge", pd_active, 0);
    pulse_ref();
    chk("R6", "pd after two edges", pd_active, 1);
    send(24'h000000);
    chk("R5", "pd release after sync", pd_active, 0);
    // R5 cancel pending sync power-down
    send(24'h300000);
    pulse_ref();
    send(24'h000000);
    pulse_ref(); pulse_ref();
    chk("R5", "cancelled pending pd", pd_active, 0);

    // R9 test word gating
    send(24'hABCDEF);
    chk("R9", "test_q gated off", test_q, 0);
    check_rb("R9");
    send(mk_ref(14'd5, 2'd0, 1'b0, 1'b1, 2'd0, 2'd0));
    chk("R9", "test_q enabled", test_q, 24'hABCDEF >> 2);
    send(mk_ref(14'd5, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0));
    chk("R9", "test_q disabled again", test_q, 0);
    check_fields("R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule